// File: doc/BRIEF.md
# Instruction Fetch Next-PC Unit

This block holds the program counter of a single-cycle processor and works out the next fetch address once per clock. The current PC leaves the block as the instruction-memory address. The word that the memory returns for that address comes back in and is passed straight out to the decoder in the same cycle. The memory itself sits outside the block.

The next address is chosen from three candidates. The sequential candidate is PC+4. The conditional candidate is PC+4 plus a sign-extended 16-bit word offset. The absolute candidate keeps the top nibble of PC+4 and takes the remaining bits from a 26-bit word target. Decode and operand comparison happen upstream. The block only sees a branch select, a jump select and the zero flag from the ALU.

Top module: `fetch_npc_unit`

## Requirements
- R1: While rst_ni is low, pc_o equals RESET_ADDR with its two low bits cleared. The reset is asynchronous: pc_o takes that value as soon as rst_ni falls, without waiting for a clock edge.
- R2: On a rising edge with branch_sel_i=0 and jump_sel_i=0, the PC advances by 4.
- R3: instr_o equals imem_rdata_i in the same cycle, with no register in between.
- R4: On a rising edge with branch_sel_i=1, zero_i=1 and jump_sel_i=0, the PC becomes PC+4+(sign-extended imm16_i × 4).
- R5: On a rising edge with branch_sel_i=1, zero_i=0 and jump_sel_i=0, the PC becomes PC+4.
- R6: When branch_sel_i=0, zero_i has no effect on the next PC.
- R7: On a rising edge with jump_sel_i=1, the PC becomes {PC+4 bits 31:28, target_i, 2'b00}.
- R8: Jump has priority over branch. With jump_sel_i=1, branch_sel_i and zero_i are ignored.
- R9: pc_o bits 1:0 are always 0.
- R10: All address arithmetic is modulo 2^32. PC+4 from 0xFFFFFFFC gives 0, and a backward offset from a low PC wraps to the top of the space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the PC updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| branch_sel_i | input | 1 | Current instruction is a conditional branch |
| zero_i | input | 1 | ALU zero flag (operands equal) |
| jump_sel_i | input | 1 | Current instruction is an absolute jump |
| imm16_i | input | 16 | Signed branch offset in words |
| target_i | input | 26 | Jump target in words |
| imem_rdata_i | input | 32 | Instruction word read from memory at pc_o |
| pc_o | output | 32 | Current PC, used as the instruction-memory address |
| instr_o | output | 32 | Fetched instruction word |

## Verification
A corrupted PC register or a wrong candidate selection shows on pc_o one rising edge after the bad input. Because the PC feeds its own next value, the error then stays in every later address, so a single-step comparison against an arithmetic model finds it immediately. A fault in the pass-through shows on instr_o in the same cycle. A fault in the low-bit handling shows on pc_o bits 1:0 at any time.

// File: rtl/fetch_npc_pkg.sv
package fetch_npc_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_BRANCH = 2'd1,
    NPC_JUMP   = 2'd2
  } npc_kind_e;
endpackage

// File: rtl/fetch_npc_sel.sv
module fetch_npc_sel
  import fetch_npc_pkg::*;
(
  input  logic      branch_sel_i,
  input  logic      zero_i,
  input  logic      jump_sel_i,
  output npc_kind_e kind_o
);
  // jump wins over a taken branch
  always_comb begin
    if (jump_sel_i)                  kind_o = NPC_JUMP;
    else if (branch_sel_i && zero_i) kind_o = NPC_BRANCH;
    else                             kind_o = NPC_SEQ;
  end
endmodule

// File: rtl/fetch_target_gen.sv
module fetch_target_gen #(
  parameter int unsigned WORD_W = 30,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned TGT_W  = 26
) (
  input  logic [WORD_W-1:0] pc_word_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [TGT_W-1:0]  tgt_i,
  output logic [WORD_W-1:0] seq_o,
  output logic [WORD_W-1:0] br_o,
  output logic [WORD_W-1:0] jmp_o
);
  localparam int unsigned HI_W  = WORD_W - TGT_W;
  localparam int unsigned EXT_W = WORD_W - IMM_W;

  logic [WORD_W-1:0] off_word;

  // word units: the x4 scaling is implicit in dropping the low two bits
  assign off_word = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign seq_o    = pc_word_i + WORD_W'(1);
  assign br_o     = seq_o + off_word;
  assign jmp_o    = {seq_o[WORD_W-1 -: HI_W], tgt_i};
endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg #(
  parameter int unsigned        WORD_W     = 30,
  parameter logic [WORD_W-1:0]  RESET_WORD = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] d_i,
  output logic [WORD_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RESET_WORD;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/fetch_npc_unit.sv
module fetch_npc_unit
  import fetch_npc_pkg::*;
#(
  parameter int unsigned       XLEN       = 32,
  parameter int unsigned       IMM_W      = 16,
  parameter int unsigned       TGT_W      = 26,
  parameter int unsigned       INSTR_W    = 32,
  parameter logic [XLEN-1:0]   RESET_ADDR = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               branch_sel_i,
  input  logic               zero_i,
  input  logic               jump_sel_i,
  input  logic [IMM_W-1:0]   imm16_i,
  input  logic [TGT_W-1:0]   target_i,
  input  logic [INSTR_W-1:0] imem_rdata_i,
  output logic [XLEN-1:0]    pc_o,
  output logic [INSTR_W-1:0] instr_o
);
  localparam int unsigned WORD_W = XLEN - 2;
  localparam logic [WORD_W-1:0] RESET_WORD = RESET_ADDR[XLEN-1:2];

  npc_kind_e         kind;
  logic [WORD_W-1:0] pc_word, seq_word, br_word, jmp_word, next_word;

  fetch_npc_sel u_sel (
    .branch_sel_i (branch_sel_i),
    .zero_i       (zero_i),
    .jump_sel_i   (jump_sel_i),
    .kind_o       (kind)
  );

  fetch_target_gen #(
    .WORD_W (WORD_W),
    .IMM_W  (IMM_W),
    .TGT_W  (TGT_W)
  ) u_tgt (
    .pc_word_i (pc_word),
    .imm_i     (imm16_i),
    .tgt_i     (target_i),
    .seq_o     (seq_word),
    .br_o      (br_word),
    .jmp_o     (jmp_word)
  );

  always_comb begin
    unique case (kind)
      NPC_BRANCH: next_word = br_word;
      NPC_JUMP:   next_word = jmp_word;
      default:    next_word = seq_word;
    endcase
  end

  fetch_pc_reg #(
    .WORD_W     (WORD_W),
    .RESET_WORD (RESET_WORD)
  ) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (next_word),
    .q_o    (pc_word)
  );

  assign pc_o    = {pc_word, 2'b00};
  assign instr_o = imem_rdata_i;
endmodule

// File: rtl/fetch_npc_unit_chk.sv
module fetch_npc_unit_chk #(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     IMM_W      = 16,
  parameter int unsigned     TGT_W      = 26,
  parameter int unsigned     INSTR_W    = 32,
  parameter logic [XLEN-1:0] RESET_ADDR = '0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               branch_sel_i,
  input logic               zero_i,
  input logic               jump_sel_i,
  input logic [IMM_W-1:0]   imm16_i,
  input logic [TGT_W-1:0]   target_i,
  input logic [INSTR_W-1:0] imem_rdata_i,
  input logic [XLEN-1:0]    pc_o,
  input logic [INSTR_W-1:0] instr_o
);
  localparam int unsigned HI_W  = XLEN - TGT_W - 2;
  localparam int unsigned EXT_W = XLEN - IMM_W - 2;
  localparam logic [XLEN-1:0] RST_PC = {RESET_ADDR[XLEN-1:2], 2'b00};

  logic [XLEN-1:0] pc_plus4, br_dest, jmp_dest;
  assign pc_plus4 = pc_o + XLEN'(4);
  assign br_dest  = pc_plus4 + {{EXT_W{imm16_i[IMM_W-1]}}, imm16_i, 2'b00};
  assign jmp_dest = {pc_plus4[XLEN-1 -: HI_W], target_i, 2'b00};

  a_r1_reset_value: assert property (@(posedge clk_i)
    !rst_ni |-> pc_o == RST_PC);

  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!branch_sel_i && !jump_sel_i) |=> pc_o == $past(pc_plus4));

  a_r3_passthru: assert property (@(posedge clk_i)
    instr_o == imem_rdata_i);

  a_r4_branch_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_sel_i && zero_i && !jump_sel_i) |=> pc_o == $past(br_dest));

  a_r5_branch_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_sel_i && !zero_i && !jump_sel_i) |=> pc_o == $past(pc_plus4));

  a_r7_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_sel_i |=> pc_o == $past(jmp_dest));

  a_r9_aligned: assert property (@(posedge clk_i)
    pc_o[1:0] == 2'b00);
endmodule

bind fetch_npc_unit fetch_npc_unit_chk #(
  .XLEN       (XLEN),
  .IMM_W      (IMM_W),
  .TGT_W      (TGT_W),
  .INSTR_W    (INSTR_W),
  .RESET_ADDR (RESET_ADDR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .branch_sel_i (branch_sel_i),
  .zero_i       (zero_i),
  .jump_sel_i   (jump_sel_i),
  .imm16_i      (imm16_i),
  .target_i     (target_i),
  .imem_rdata_i (imem_rdata_i),
  .pc_o         (pc_o),
  .instr_o      (instr_o)
);

// File: tb/fetch_npc_unit_test.sv
`timescale 1ns/1ps
module fetch_npc_unit_test;
  localparam logic [31:0] RST_A = 32'h0000_1003; // low bits must be dropped
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        branch_sel_i = 1'b0, zero_i = 1'b0, jump_sel_i = 1'b0;
  logic [15:0] imm16_i = '0;
  logic [25:0] target_i = '0;
  logic [31:0] imem_rdata_i = '0;
  logic [31:0] pc_o, instr_o;

  int unsigned n_chk = 0, n_bad = 0;
  logic [31:0] exp_pc;

  always #2.5 clk = ~clk;

  fetch_npc_unit #(.RESET_ADDR(RST_A)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .branch_sel_i(branch_sel_i), .zero_i(zero_i),
    .jump_sel_i(jump_sel_i), .imm16_i(imm16_i), .target_i(target_i),
    .imem_rdata_i(imem_rdata_i), .pc_o(pc_o), .instr_o(instr_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [31:0] pc, logic br, logic z,
                                        logic jmp, logic [15:0] imm, logic [25:0] tgt);
    logic [31:0] p4;
    p4 = pc + 32'd4;
    if (jmp)          return {p4[31:28], tgt, 2'b00};
    else if (br && z) return p4 + (32'(signed'(imm)) * 32'sd4);
    else              return p4;
  endfunction

  // called at a negedge; applies inputs, waits one rising edge, checks at next negedge
  task automatic step(logic br, logic z, logic jmp, logic [15:0] imm, logic [25:0] tgt);
    string tag;
    logic [31:0] nxt;
    branch_sel_i = br; zero_i = z; jump_sel_i = jmp; imm16_i = imm; target_i = tgt;
    nxt = model(exp_pc, br, z, jmp, imm, tgt);
    if (jmp && br)    tag = "R8";
    else if (jmp)     tag = "R7";
    else if (br && z) tag = "R4";
    else if (br)      tag = "R5";
    else if (z)       tag = "R6";
    else              tag = "R2";
    @(posedge clk);
    @(negedge clk);
    check(tag, pc_o, nxt);
    check("R9", {30'd0, pc_o[1:0]}, 32'd0);
    exp_pc = nxt;
    imem_rdata_i = ~pc_o ^ 32'h5A5A_0F0F;
    #0.5;
    check("R3", instr_o, ~pc_o ^ 32'h5A5A_0F0F);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    #0.5 check("R1", pc_o, RST_PC);
    @(negedge clk);
    @(negedge clk);
    check("R1", pc_o, RST_PC);
    rst_ni = 1'b1;
    exp_pc = RST_PC;
    @(negedge clk);
    check("R1", pc_o, RST_PC + 32'd4); // first edge after release moves sequentially
    exp_pc = RST_PC + 32'd4;

    // R10: wrap via backward branch and sequential overflow
    step(1'b0, 1'b0, 1'b1, 16'h0, 26'h0);       // jump to 0
    step(1'b1, 1'b1, 1'b0, 16'hFFFE, 26'h0);    // 0+4-8 -> FFFFFFFC
    check("R10", pc_o, 32'hFFFF_FFFC);
    step(1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
    check("R10", pc_o, 32'h0000_0000);
    step(1'b1, 1'b1, 1'b0, 16'h7FFF, 26'h0);    // max forward offset
    step(1'b1, 1'b1, 1'b0, 16'h8000, 26'h0);    // max backward offset

    // sweep all select combinations against varied offsets and targets
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] h;
      h = 32'(i) * 32'h9E37_79B1;
      step(h[3], h[5], h[7] & h[9], h[31:16] ^ 16'(i), h[25:0]);
    end

    // async reset mid-cycle
    @(posedge clk); #1 rst_ni = 1'b0;
    #0.2 check("R1", pc_o, RST_PC);
    @(negedge clk);
    check("R1", pc_o, RST_PC);
    rst_ni = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule